// File: doc/BRIEF.md
# FIFO Occupancy High-Water-Mark Register

This block keeps a running record of how full two FIFOs have become. Every clock it compares the present fill level of a transmit FIFO and of a receive FIFO with the largest level it has stored for each. When the present level is strictly larger, it keeps the new level. Both peaks sit in one 32-bit word that the host can read and write. Software uses the word to size queues on platforms whose bus latency and clock rate differ.

A read only observes the stored peaks and never disturbs them. The peaks drop only when the host writes the word. Writing zero starts a fresh measurement, and a non-zero write preloads a floor. Tracking carries on in every cycle, including the cycle after a write.

Top module: `hwm_fifo_peak_reg`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, both stored peaks are zero and a read of the register returns 0x00000000.
- R2: The transmit peak sits in read-data bits 9:0. It takes the transmit level sampled at a clock edge when that level is strictly greater than the stored peak and no host write to the register occurs in that cycle.
- R3: The receive peak sits in read-data bits 19:10. It takes the receive level sampled at a clock edge under the same strictly-greater rule as R2.
- R4: Without a host write to the register, a level equal to or below the stored peak leaves that peak unchanged, so a peak never decreases.
- R5: Read-data bits 31:20 always read as zero, even after the host writes ones to them.
- R6: Reading the register, by holding host_addr at 0x18 for any number of cycles, does not change the stored peaks.
- R7: A host write (host_wr high with host_addr equal to 0x18) loads the transmit peak from host_wdata[9:0] and the receive peak from host_wdata[19:10]. Writing zero restarts the measurement.
- R8: When a host write and a larger level arrive in the same cycle, the written value is stored. The level present in the next cycle is then compared against the written value.
- R9: A write to any other address leaves both peaks unchanged, and a read at any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 8 | Byte offset of the host access within the register space |
| host_wr | input | 1 | Write strobe, one write per high cycle |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid in the same cycle as host_addr |
| tx_level | input | 10 | Present transmit FIFO occupancy |
| rx_level | input | 10 | Present receive FIFO occupancy |

## Verification
The tracking rule is tried with three kinds of level: rising levels, which show that a new maximum is captured in each field separately; falling levels, which show that the peak is sticky; and levels equal to the stored peak, which separate a strictly-greater compare from a greater-or-equal one. Levels at the full-scale value 1023 and the upper bits of the written word show that the fields stay in their own bit positions and do not spill into each other. Writes made together with a larger level show that the written value has priority and that comparison resumes in the next cycle. Writes and reads at a neighbouring offset show that the address decode isolates the register.

// File: rtl/hwm_pkg.sv
package hwm_pkg;
    localparam int LVL_W   = 10;
    localparam int REG_W   = 32;
    localparam int NUM_CH  = 2;
    localparam int CH_TX   = 0;
    localparam int CH_RX   = 1;
    localparam int FIELD_W = NUM_CH * LVL_W;
    localparam int PAD_W   = REG_W - FIELD_W;

    typedef logic [LVL_W-1:0] level_t;

    typedef struct packed {
        level_t [NUM_CH-1:0] peak;
    } peak_state_t;
endpackage

// File: rtl/hwm_addr_match.sv
module hwm_addr_match #(
    parameter int                ADDR_W = 8,
    parameter logic [ADDR_W-1:0] OFS    = 8'h18
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic              hit,
    output logic              wr_hit
);
    always_comb begin
        hit    = (addr == OFS);
        wr_hit = hit & wr;
    end
endmodule

// File: rtl/hwm_peak_next.sv
module hwm_peak_next #(
    parameter int W = 10
) (
    input  logic [W-1:0] cur_peak,
    input  logic [W-1:0] level,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] nxt_peak
);
    always_comb begin
        if (load) begin
            nxt_peak = load_val;          // host write wins over tracking
        end else if (level > cur_peak) begin
            nxt_peak = level;             // strictly greater only
        end else begin
            nxt_peak = cur_peak;
        end
    end
endmodule

// File: rtl/hwm_fifo_peak_reg.sv
module hwm_fifo_peak_reg
    import hwm_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] REG_OFS = 8'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [REG_W-1:0]  host_wdata,
    output logic [REG_W-1:0]  host_rdata,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level
);
    peak_state_t          st_d, st_q;
    level_t [NUM_CH-1:0]  lvl;
    level_t [NUM_CH-1:0]  wfield;
    level_t [NUM_CH-1:0]  nxt;
    logic                 reg_hit;
    logic                 reg_wr;

    assign lvl[CH_TX] = tx_level;
    assign lvl[CH_RX] = rx_level;

    hwm_addr_match #(
        .ADDR_W (ADDR_W),
        .OFS    (REG_OFS)
    ) u_match (
        .addr   (host_addr),
        .wr     (host_wr),
        .hit    (reg_hit),
        .wr_hit (reg_wr)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        assign wfield[ch] = host_wdata[ch*LVL_W +: LVL_W];

        hwm_peak_next #(
            .W (LVL_W)
        ) u_next (
            .cur_peak (st_q.peak[ch]),
            .level    (lvl[ch]),
            .load     (reg_wr),
            .load_val (wfield[ch]),
            .nxt_peak (nxt[ch])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.peak = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // channel 1 (receive) lands in the upper field, channel 0 in the lower
    always_comb begin
        host_rdata = '0;
        if (reg_hit) begin
            host_rdata = {{PAD_W{1'b0}}, st_q.peak};
        end
    end
endmodule

// File: rtl/hwm_fifo_peak_reg_chk.sv
module hwm_fifo_peak_reg_chk
    import hwm_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] REG_OFS = 8'h18
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_wr,
    input logic [REG_W-1:0]  host_wdata,
    input logic [REG_W-1:0]  host_rdata,
    input logic [LVL_W-1:0]  tx_level,
    input logic [LVL_W-1:0]  rx_level,
    input logic [LVL_W-1:0]  tx_peak,
    input logic [LVL_W-1:0]  rx_peak
);
    logic wr_hit;
    assign wr_hit = host_wr && (host_addr == REG_OFS);

    AST_RST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (tx_peak == '0 && rx_peak == '0)); // R1

    AST_TX_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && tx_level > tx_peak) |=> (tx_peak == $past(tx_level))); // R2

    AST_RX_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && rx_level > rx_peak) |=> (rx_peak == $past(rx_level))); // R3

    AST_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> (tx_peak >= $past(tx_peak) && rx_peak >= $past(rx_peak))); // R4

    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[REG_W-1:FIELD_W] == '0); // R5

    AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (tx_peak == $past(host_wdata[LVL_W-1:0]) &&
                    rx_peak == $past(host_wdata[FIELD_W-1:LVL_W]))); // R7

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr != REG_OFS) |-> (host_rdata == '0)); // R9
endmodule

bind hwm_fifo_peak_reg hwm_fifo_peak_reg_chk #(
    .ADDR_W  (ADDR_W),
    .REG_OFS (REG_OFS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .tx_level   (tx_level),
    .rx_level   (rx_level),
    .tx_peak    (st_q.peak[hwm_pkg::CH_TX]),
    .rx_peak    (st_q.peak[hwm_pkg::CH_RX])
);

// File: tb/hwm_fifo_peak_reg_tb.sv
`timescale 1ns/1ps
module hwm_fifo_peak_reg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  host_addr = 8'h18;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [9:0]  tx_level = '0;
    logic [9:0]  rx_level = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hwm_fifo_peak_reg u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .tx_level   (tx_level),
        .rx_level   (rx_level)
    );

    // {req, wr, addr, wdata, rx, tx, expected word read at 0x18 after the edge}
    typedef struct packed {
        logic [7:0]  req;
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [9:0]  rx;
        logic [9:0]  tx;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{8'd2, 1'b0, 8'h18, 32'h0,        10'd5,    10'd3,   32'h0000_1403}, // R2 R3 rise
        '{8'd4, 1'b0, 8'h18, 32'h0,        10'd2,    10'd1,   32'h0000_1403}, // R4 lower
        '{8'd4, 1'b0, 8'h18, 32'h0,        10'd5,    10'd3,   32'h0000_1403}, // R4 equal
        '{8'd3, 1'b0, 8'h18, 32'h0,        10'd1023, 10'd512, 32'h000F_FE00}, // R3 full scale
        '{8'd8, 1'b1, 8'h18, 32'h0,        10'd7,    10'd9,   32'h0000_0000}, // R8 R7 restart
        '{8'd8, 1'b0, 8'h18, 32'h0,        10'd7,    10'd9,   32'h0000_1C09}, // R8 next cycle
        '{8'd9, 1'b1, 8'h14, 32'h0,        10'd0,    10'd0,   32'h0000_1C09}, // R9 other address
        '{8'd5, 1'b1, 8'h18, 32'hFFF0_4020, 10'd0,   10'd0,   32'h0000_4020}, // R5 R7 preload
        '{8'd7, 1'b0, 8'h18, 32'h0,        10'd16,   10'd33,  32'h0000_4021}  // R7 floor kept
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset held", host_rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 after release", host_rdata, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            host_wr    = VECS[i].wr;
            host_addr  = VECS[i].addr;
            host_wdata = VECS[i].wdata;
            rx_level   = VECS[i].rx;
            tx_level   = VECS[i].tx;
            @(posedge clk);
            #1;
            host_wr   = 1'b0;
            host_addr = 8'h18;
            #0.5;
            checks++;
            if (host_rdata !== VECS[i].exp) begin
                failures++;
                $display("FAIL vector %0d R%0d actual=%08h expected=%08h",
                         i, VECS[i].req, host_rdata, VECS[i].exp);
            end
        end

        // R6: repeated reads leave the peaks alone
        @(negedge clk);
        rx_level = '0;
        tx_level = '0;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            #1;
            check("R6 repeated read", host_rdata, 32'h0000_4021);
        end

        // R9: read at another offset returns zero
        @(negedge clk);
        host_addr = 8'h1C;
        #1;
        check("R9 read miss", host_rdata, 32'h0);
        host_addr = 8'h18;

        // R1: reset mid-run clears
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 mid-run reset", host_rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule